// File: doc/BRIEF.md
# Single-Move Datapath Core

This core executes one kind of instruction only: a copy of one data word from a source address to a destination address. A 16-bit instruction word arrives from an instruction store that is separate from data storage. The instruction is split into a source field and a destination field. These fields drive two separate address buses, and one shared data bus carries the copied word. Fetch, read and write all complete in a single clock cycle. Every other effect comes from the location that is written or read. This includes jumps, constants, arithmetic and draining a queue.

The top sixteen addresses hold the internal registers:

| Address | Register |
|---|---|
| 0xF0 | Program counter |
| 0xF1 | Immediate register |
| 0xF2 | ALU operand A |
| 0xF3 | ALU operand B |
| 0xF4 | ALU function select |
| 0xF5 | ALU result |
| 0xF6 | Receive-queue data |
| 0xF7 | Receive-queue status |
| 0xF8–0xFF | Unused |

Everything below 0xF0 is an on-chip data RAM with synchronous write and combinational read. An external producer pushes bytes into the receive queue. The program pops those bytes by reading the queue data address.

Top module: `move_core`

## Requirements
- R1: The source address bus carries bits [15:8] of the instruction and the destination address bus carries bits [7:0]. The instruction is the one at the current program counter, which is also driven on the instruction address output.
- R2: When the read strobe is high, the data bus carries the value at the source address. That value is stored at the destination by the next clock edge; for a RAM destination (0x00–0xEF), the RAM word is written.
- R3: A move whose destination is 0xF1 loads the source address field into the immediate register. During that move the read strobe is low, the data bus is 0, and no queue entry is popped. Reading 0xF1 returns the immediate register.
- R4: The program counter resets to 0. It advances by one after every move, except a move into 0xF0, which loads the data bus value as the next fetch address. Reading 0xF0 returns the address of the executing instruction.
- R5: Addresses 0xF2, 0xF3 and 0xF4 are write-only and read as 0. They hold operand A, operand B and the function select (bits [2:0]). Reading 0xF5 gives the combinational result for the function codes below.

  | Code | Result |
  |---|---|
  | 0 | A+B |
  | 1 | A−B |
  | 2 | A&B |
  | 3 | A\|B |
  | 4 | A^B |
  | 5 | ~A |
  | 6 | A<<1 |
  | 7 | A>>1 |

  All results are taken modulo 256.
- R6: The receive queue holds four entries. A push while the queue is full is dropped. Reading 0xF6 returns the oldest entry and removes it; reading 0xF6 when the queue is empty returns 0 and changes nothing. Reading 0xF7 returns the status byte {full, empty, count[5:0]}, and the full output shows the full flag.
- R7: Reads of 0xF8–0xFF return 0, and writes to them have no effect.
- R8: A move whose source and destination are the same RAM address leaves that word unchanged.
- R9: After reset, the immediate register, both ALU operands and the function select are 0, and the queue is empty.
- R10: The write strobe is high exactly when the destination is a RAM address. The read strobe is high for every move except a move into 0xF1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| imem_addr_o | output | 8 | Instruction fetch address (program counter) |
| imem_data_i | input | 16 | Instruction word at imem_addr_o |
| src_addr_o | output | 8 | Source address bus |
| dst_addr_o | output | 8 | Destination address bus |
| data_o | output | 8 | Data bus |
| rd_en_o | output | 1 | Source read strobe |
| wr_en_o | output | 1 | RAM write strobe |
| fifo_push_i | input | 1 | Push a byte into the receive queue |
| fifo_data_i | input | 8 | Byte to push |
| fifo_full_o | output | 1 | Receive queue is full |

## Verification
The hardest case to reach is a move into the immediate register whose source field is the queue data address. Proving that this move pops nothing requires a full queue, then the suppressed read, and then a status read that shows the same count. The program fills the queue from the bench while the ALU sequence is running. It then moves 0xF6 into the immediate register and reads the status before and after. It drains the queue past empty, and a jump skips over an instruction that must never execute. A behavioural model built on a queue and an array predicts every bus value on every cycle.

// File: rtl/move_pkg.sv
package move_pkg;
  localparam int unsigned NUM_REGS = 8;
  localparam logic [3:0] OFS_PC    = 4'd0;
  localparam logic [3:0] OFS_IMM   = 4'd1;
  localparam logic [3:0] OFS_OPA   = 4'd2;
  localparam logic [3:0] OFS_OPB   = 4'd3;
  localparam logic [3:0] OFS_FN    = 4'd4;
  localparam logic [3:0] OFS_RES   = 4'd5;
  localparam logic [3:0] OFS_FDAT  = 4'd6;
  localparam logic [3:0] OFS_FSTAT = 4'd7;

  typedef enum logic [2:0] {
    FN_ADD, FN_SUB, FN_AND, FN_OR, FN_XOR, FN_NOTA, FN_SHL, FN_SHR
  } alu_fn_e;
endpackage

// File: rtl/move_alu.sv
module move_alu import move_pkg::*; #(
  parameter int unsigned DW = 8
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  alu_fn_e       fn_i,
  output logic [DW-1:0] res_o
);
  always_comb begin
    unique case (fn_i)
      FN_ADD:  res_o = a_i + b_i;
      FN_SUB:  res_o = a_i - b_i;
      FN_AND:  res_o = a_i & b_i;
      FN_OR:   res_o = a_i | b_i;
      FN_XOR:  res_o = a_i ^ b_i;
      FN_NOTA: res_o = ~a_i;
      FN_SHL:  res_o = a_i << 1;
      FN_SHR:  res_o = a_i >> 1;
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/move_fifo.sv
module move_fifo #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] din_i,
  input  logic          pop_i,
  output logic [DW-1:0] dout_o,
  output logic [$clog2(DEPTH+1)-1:0] count_o,
  output logic          full_o,
  output logic          empty_o
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH+1);

  logic [DW-1:0] mem_q [DEPTH];
  logic [PW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] cnt_q;
  logic          push_ok, pop_ok;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign push_ok = push_i && !full_o;
  assign pop_ok  = pop_i && !empty_o;
  assign dout_o  = empty_o ? '0 : mem_q[rd_ptr_q];
  assign count_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_ok) begin
        mem_q[wr_ptr_q] <= din_i;
        wr_ptr_q <= (wr_ptr_q == PW'(DEPTH-1)) ? '0 : wr_ptr_q + 1'b1;
      end
      if (pop_ok)
        rd_ptr_q <= (rd_ptr_q == PW'(DEPTH-1)) ? '0 : rd_ptr_q + 1'b1;
      cnt_q <= cnt_q + CW'(push_ok) - CW'(pop_ok);
    end
  end

  p_no_overflow_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
  p_empty_pop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && empty_o && !push_i) |=> (cnt_q == '0));
  p_full_drop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && !pop_i) |=> $stable(cnt_q));
endmodule

// File: rtl/move_ram.sv
module move_ram #(
  parameter int unsigned DW    = 8,
  parameter int unsigned WORDS = 240
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [DW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [WORDS];

  assign rdata_o = (raddr_i < DW'(WORDS)) ? mem_q[raddr_i] : '0;

  always_ff @(posedge clk_i) begin
    if (we_i && (waddr_i < DW'(WORDS))) mem_q[waddr_i] <= wdata_i;
  end

  // same-address move must leave the word as it was read
  logic          same_q;
  logic [DW-1:0] same_addr_q, same_val_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      same_q      <= 1'b0;
      same_addr_q <= '0;
      same_val_q  <= '0;
    end else begin
      same_q      <= we_i && (waddr_i == raddr_i) && (raddr_i < DW'(WORDS));
      same_addr_q <= raddr_i;
      same_val_q  <= rdata_o;
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_ni && same_q)
      p_same_addr_r8: assert (mem_q[same_addr_q] == same_val_q);
  end
endmodule

// File: rtl/move_core.sv
module move_core import move_pkg::*; #(
  parameter int unsigned DW         = 8,
  parameter logic [7:0]  REG_BASE   = 8'hF0,
  parameter int unsigned FIFO_DEPTH = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  output logic [7:0]  imem_addr_o,
  input  logic [15:0] imem_data_i,
  output logic [7:0]  src_addr_o,
  output logic [7:0]  dst_addr_o,
  output logic [7:0]  data_o,
  output logic        rd_en_o,
  output logic        wr_en_o,
  input  logic        fifo_push_i,
  input  logic [7:0]  fifo_data_i,
  output logic        fifo_full_o
);
  localparam int unsigned IW = 2 * DW;
  localparam int unsigned CW = $clog2(FIFO_DEPTH + 1);
  localparam int unsigned RAM_WORDS = int'(REG_BASE);

  function automatic logic [DW-1:0] reg_addr(input logic [3:0] ofs);
    return DW'(REG_BASE) + DW'(ofs);
  endfunction

  logic [DW-1:0] pc_q, imm_q, opa_q, opb_q, res;
  alu_fn_e       fn_q;
  logic [DW-1:0] src, dst, src_rel, rd_val, ram_rdata, fifo_dout, bus;
  logic          src_is_reg, dst_is_reg, fifo_pop, fifo_empty;
  logic [CW-1:0] fifo_cnt;

  assign src        = imem_data_i[IW-1:DW];
  assign dst        = imem_data_i[DW-1:0];
  assign src_is_reg = (src >= DW'(REG_BASE));
  assign dst_is_reg = (dst >= DW'(REG_BASE));
  assign src_rel    = src - DW'(REG_BASE);

  assign rd_en_o  = (dst != reg_addr(OFS_IMM));
  assign wr_en_o  = !dst_is_reg;
  assign fifo_pop = rd_en_o && (src == reg_addr(OFS_FDAT));

  always_comb begin
    rd_val = '0;
    if (!src_is_reg) rd_val = ram_rdata;
    else if (src_rel < DW'(NUM_REGS)) begin
      case (src_rel[3:0])
        OFS_PC:    rd_val = pc_q;
        OFS_IMM:   rd_val = imm_q;
        OFS_RES:   rd_val = res;
        OFS_FDAT:  rd_val = fifo_dout;
        OFS_FSTAT: rd_val = {fifo_full_o, fifo_empty, (DW-2)'(fifo_cnt)};
        default:   rd_val = '0;
      endcase
    end
  end

  assign bus = rd_en_o ? rd_val : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q  <= '0;
      imm_q <= '0;
      opa_q <= '0;
      opb_q <= '0;
      fn_q  <= FN_ADD;
    end else begin
      pc_q <= (dst == reg_addr(OFS_PC)) ? bus : pc_q + 1'b1;
      if (dst == reg_addr(OFS_IMM)) imm_q <= src;
      if (dst == reg_addr(OFS_OPA)) opa_q <= bus;
      if (dst == reg_addr(OFS_OPB)) opb_q <= bus;
      if (dst == reg_addr(OFS_FN))  fn_q  <= alu_fn_e'(bus[2:0]);
    end
  end

  move_alu #(.DW(DW)) u_alu (
    .a_i(opa_q), .b_i(opb_q), .fn_i(fn_q), .res_o(res)
  );

  move_fifo #(.DW(DW), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i, .rst_ni,
    .push_i(fifo_push_i), .din_i(fifo_data_i), .pop_i(fifo_pop),
    .dout_o(fifo_dout), .count_o(fifo_cnt), .full_o(fifo_full_o), .empty_o(fifo_empty)
  );

  move_ram #(.DW(DW), .WORDS(RAM_WORDS)) u_ram (
    .clk_i, .rst_ni,
    .we_i(wr_en_o), .waddr_i(dst), .wdata_i(bus),
    .raddr_i(src), .rdata_o(ram_rdata)
  );

  assign imem_addr_o = pc_q;
  assign src_addr_o  = src;
  assign dst_addr_o  = dst;
  assign data_o      = bus;

  p_imm_latch_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_o |=> (imm_q == $past(src_addr_o)));
  p_no_pop_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_o |=> (fifo_cnt >= $past(fifo_cnt)));
  p_pc_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dst_addr_o != reg_addr(OFS_PC)) |=> (imem_addr_o == $past(imem_addr_o) + 1'b1));
  p_pc_jump_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dst_addr_o == reg_addr(OFS_PC)) |=> (imem_addr_o == $past(data_o)));
  p_unmapped_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_is_reg && src_rel >= DW'(NUM_REGS)) |-> (data_o == '0));
  p_write_ram_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (dst_addr_o < DW'(REG_BASE)));
endmodule

// File: tb/sim_move_core.sv
module sim_move_core;
  localparam int NCYC = 120;
  localparam int DEPTH = 4;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [7:0]  imem_addr, src_addr, dst_addr, data;
  logic [15:0] imem_data;
  logic        rd_en, wr_en, fifo_push = 1'b0, fifo_full;
  logic [7:0]  fifo_data = '0;

  logic [15:0] prog [256];
  int          ptr = 0;
  int          vectors = 0, errors = 0;
  bit          done = 1'b0;

  logic [7:0] m_pc, m_imm, m_a, m_b, m_f;
  logic [7:0] m_ram [256];
  logic [7:0] m_q [$];
  bit         after_same;

  always #4 clk = ~clk;

  assign imem_data = prog[imem_addr];

  move_core u0 (
    .clk_i(clk), .rst_ni(rst_n), .imem_addr_o(imem_addr), .imem_data_i(imem_data),
    .src_addr_o(src_addr), .dst_addr_o(dst_addr), .data_o(data),
    .rd_en_o(rd_en), .wr_en_o(wr_en),
    .fifo_push_i(fifo_push), .fifo_data_i(fifo_data), .fifo_full_o(fifo_full)
  );

  task automatic mv(input logic [7:0] s, input logic [7:0] d);
    prog[ptr] = {s, d};
    ptr++;
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h (pc %02h)", req, act, exp, m_pc);
    end
  endtask

  function automatic logic [7:0] alu(input logic [7:0] a, b, input logic [2:0] f);
    case (f)
      3'd0: return a + b;
      3'd1: return a - b;
      3'd2: return a & b;
      3'd3: return a | b;
      3'd4: return a ^ b;
      3'd5: return ~a;
      3'd6: return a << 1;
      default: return a >> 1;
    endcase
  endfunction

  function automatic logic [7:0] status();
    int n = m_q.size();
    return {n == DEPTH, n == 0, 6'(n)};
  endfunction

  function automatic logic [7:0] m_read(input logic [7:0] s);
    if (s < 8'hF0) return m_ram[s];
    case (s)
      8'hF0: return m_pc;
      8'hF1: return m_imm;
      8'hF5: return alu(m_a, m_b, m_f[2:0]);
      8'hF6: return (m_q.size() > 0) ? m_q[0] : 8'h00;
      8'hF7: return status();
      default: return 8'h00;
    endcase
  endfunction

  function automatic string dtag(input logic [7:0] s, input int k);
    if (k < 3) return "R9";
    if (after_same) return "R8";
    if (s == 8'hF0) return "R4";
    if (s == 8'hF1) return "R3";
    if (s >= 8'hF2 && s <= 8'hF5) return "R5";
    if (s == 8'hF6 || s == 8'hF7) return "R6";
    if (s >= 8'hF8) return "R7";
    return "R2";
  endfunction

  task automatic step(input int k);
    logic [15:0] ins = prog[m_pc];
    logic [7:0] s = ins[15:8], d = ins[7:0], val;
    bit rd = (d != 8'hF1);
    bit push = fifo_push;
    bit was_full = (m_q.size() == DEPTH);
    val = rd ? m_read(s) : 8'h00;
    chk("R4", imem_addr, m_pc);
    chk("R1", src_addr, s);
    chk("R1", dst_addr, d);
    chk("R10", 8'(rd_en), 8'(rd));
    chk("R10", 8'(wr_en), 8'(d < 8'hF0));
    chk("R6", 8'(fifo_full), 8'(was_full));
    if (!$isunknown(val)) chk(dtag(s, k), data, val);
    after_same = (s == d) && (s < 8'hF0);
    // state update
    if (rd && s == 8'hF6 && m_q.size() > 0) void'(m_q.pop_front());
    if (push && !was_full) m_q.push_back(fifo_data);
    if (d < 8'hF0) m_ram[d] = val;
    if (d == 8'hF1) m_imm = s;
    if (d == 8'hF2) m_a = val;
    if (d == 8'hF3) m_b = val;
    if (d == 8'hF4) m_f = val;
    m_pc = (d == 8'hF0) ? val : m_pc + 8'd1;
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    int t;
    foreach (prog[i]) prog[i] = 16'hF8F8;
    foreach (m_ram[i]) m_ram[i] = 'x;
    m_pc = 0; m_imm = 0; m_a = 0; m_b = 0; m_f = 0; after_same = 0;
    // R9: reset values read back
    mv(8'hF1, 8'h30); mv(8'hF5, 8'h31); mv(8'hF7, 8'h32);
    mv(8'h05, 8'hF1); mv(8'hF1, 8'h10);
    mv(8'h33, 8'hF1); mv(8'hF1, 8'h11);
    mv(8'h10, 8'hF2); mv(8'h11, 8'hF3);
    for (int f = 0; f < 8; f++) begin  // R5: every function code
      mv(8'(f), 8'hF1); mv(8'hF1, 8'hF4); mv(8'hF5, 8'(8'h20 + f));
    end
    mv(8'h11, 8'h11); mv(8'h11, 8'h12);      // R8
    mv(8'hF7, 8'h33);                        // R6: full status
    mv(8'hF6, 8'hF1); mv(8'hF7, 8'h34);      // R3: no pop
    for (int i = 0; i < 5; i++) mv(8'hF6, 8'(8'h35 + i)); // R6: drain past empty
    mv(8'hF7, 8'h3A);
    mv(8'h40, 8'hF9); mv(8'hF9, 8'h3B); mv(8'hFF, 8'h3C); // R7
    mv(8'hF0, 8'h3D);                        // R4: pc read
    t = ptr + 3;
    mv(8'(t), 8'hF1); mv(8'hF1, 8'hF0); mv(8'hF1, 8'h3E); // skipped
    mv(8'hF1, 8'h3F);
    t = ptr;
    mv(8'(t), 8'hF1); mv(8'hF1, 8'hF0);

    @(negedge clk); @(negedge clk);
    chk("R9", imem_addr, 8'h00);
    chk("R9", 8'(fifo_full), 8'h00);
    rst_n = 1'b1;
    for (int k = 0; k < NCYC; k++) begin
      fifo_push = (k >= 5 && k <= 10);
      fifo_data = 8'(8'hA0 + k);
      #1;
      step(k);
      @(negedge clk);
    end
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule